// File: doc/BRIEF.md
# Infrared SIR Pulse Codec

This block converts between the NRZ serial line of a UART and the return-to-zero pulse signalling of a serial infrared transceiver. In the transmit direction, a bit-period tick from the baud generator samples the UART output. A zero bit produces one short high pulse that starts just after the tick. A one bit leaves the infrared line low for the whole bit period. Two pulse-width modes are available. The fraction mode uses three sixteenths of the bit period, computed from the baud divisor. The fixed mode uses a short width in system clocks, picked by a 3-bit select, so that the pulse clears the 1.41 µs floor of the standard at a given clock rate.

In the receive direction, the infrared input passes through a synchronizer and a rising-edge detector. Each detected pulse holds the UART-side line low for one bit period. Pulses of any width are accepted, including a single clock, because there is no minimum-width filter. A pulse that arrives inside an open window restarts it. The UART-side line is high when idle and the infrared line is low.

Top module: `irsir_codec`

## Requirements
- R1: While reset is asserted, and after it is released until the first stimulus, `ir_tx` is 0 and `rx_serial` is 1.
- R2: A cycle with `bit_tick`=1 and `tx_serial`=1 makes `ir_tx` 0 from the next cycle until the next tick.
- R3: With `width_mode`=1, a tick with `tx_serial`=0 makes `ir_tx` high for exactly 2^(`width_sel`+1) clocks, starting the cycle after the tick (value 0 gives 2 clocks, value 7 gives 256).
- R4: With `width_mode`=0, the pulse lasts floor(3·`baud_div`/16) clocks, but never less than 1 clock.
- R5: A tick that arrives while a pulse is still high restarts it: a zero bit reloads the full width from that tick, and a one bit ends the pulse at once.
- R6: If `ir_rx` is first sampled high at clock edge k after being low, `rx_serial` is 0 from edge k+2 for max(`baud_div`,1) clocks, and then returns to 1.
- R7: A received pulse of any width, including one clock, decodes as a zero bit with a full-length low window.
- R8: A new rising edge on `ir_rx` while the window is open restarts the window from that edge.
- R9: The mode, width select and divisor are taken only at the tick. Changing them while a pulse is high does not alter that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_tick | input | 1 | One-clock strobe at the start of each bit period |
| baud_div | input | 16 | Bit period in system clocks |
| width_mode | input | 1 | 1 = fixed short width, 0 = 3/16 of a bit period |
| width_sel | input | 3 | Fixed-width select, giving a pulse of 2^(sel+1) clocks |
| tx_serial | input | 1 | NRZ data from the UART transmitter |
| ir_tx | output | 1 | Pulse output to the infrared transmitter |
| ir_rx | input | 1 | Pulse input from the infrared receiver, high = light seen |
| rx_serial | output | 1 | NRZ data to the UART receiver |

## Verification
The properties assume that `bit_tick` is a single-cycle strobe, and that `tx_serial` is stable in the tick cycle. The receive properties also assume that `ir_rx` has been low for several cycles when the internal reset is released. The bench drives every input on the falling clock edge and holds `ir_rx` low through reset. It spaces ticks exactly `baud_div` clocks apart, and changes mode, select and divisor only between ticks or, on purpose, inside a pulse to show they are ignored. Received pulses come either from the bench directly, as 1-clock, wide or back-to-back pulses, or from `ir_tx` through a loopback path.

// File: rtl/irsir_pkg.sv
package irsir_pkg;
  typedef enum logic {
    PW_FRACTION = 1'b0,
    PW_FIXED    = 1'b1
  } pw_mode_e;
endpackage

// File: rtl/irsir_rst_sync.sv
module irsir_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain_q <= '0;
    else           chain_q <= chain_d;
  end

  assign rst_n_out = chain_q[STAGES-1];
endmodule

// File: rtl/irsir_tx_pulse.sv
module irsir_tx_pulse
  import irsir_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             tx_serial,
  input  logic [DIV_W-1:0] baud_div,
  input  pw_mode_e         mode,
  input  logic [SEL_W-1:0] width_sel,
  output logic             ir_tx
);
  localparam int FIX_W = (2 ** SEL_W) + 1;
  localparam int CNT_W = (DIV_W > FIX_W) ? DIV_W : FIX_W;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pulse_q, pulse_d;
  logic             cnt_en;
  logic [DIV_W+1:0] triple, frac_raw;
  logic [CNT_W-1:0] frac_w, fixed_w, load_w;
  logic [SEL_W:0]   shamt;

  always_comb begin
    triple   = {2'b00, baud_div} + {1'b0, baud_div, 1'b0};
    frac_raw = triple >> 4;
    frac_w   = (frac_raw == '0) ? CNT_W'(1) : CNT_W'(frac_raw);
    shamt    = {1'b0, width_sel} + (SEL_W+1)'(1);
    fixed_w  = CNT_W'(1) << shamt;
    load_w   = (mode == PW_FIXED) ? fixed_w : frac_w;
  end

  always_comb begin
    cnt_en = bit_tick | (cnt_q != '0);
    cnt_d  = cnt_q;
    if (bit_tick)            cnt_d = tx_serial ? '0 : load_w;
    else if (cnt_q != '0)    cnt_d = cnt_q - CNT_W'(1);
    pulse_d = (cnt_d != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q   <= cnt_d;
      pulse_q <= pulse_d;
    end
  end

  assign ir_tx = pulse_q;
endmodule

// File: rtl/irsir_rx_decode.sv
module irsir_rx_decode #(
  parameter int DIV_W  = 16,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ir_rx,
  input  logic [DIV_W-1:0] baud_div,
  output logic             rx_serial
);
  logic [SYNC_N:0]    sync_q, sync_d;
  logic               rise;
  logic [DIV_W-1:0]   win_q, win_d, win_len;
  logic               low_q, low_d;

  always_comb begin
    sync_d  = {sync_q[SYNC_N-1:0], ir_rx};
    rise    = sync_q[SYNC_N-1] & ~sync_q[SYNC_N];
    win_len = (baud_div == '0) ? DIV_W'(1) : baud_div;
    win_d   = win_q;
    if (rise)               win_d = win_len;
    else if (win_q != '0)   win_d = win_q - DIV_W'(1);
    low_d   = (win_d != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      win_q  <= '0;
      low_q  <= 1'b0;
    end else begin
      sync_q <= sync_d;
      win_q  <= win_d;
      low_q  <= low_d;
    end
  end

  assign rx_serial = ~low_q;
endmodule

// File: rtl/irsir_codec.sv
module irsir_codec
  import irsir_pkg::*;
#(
  parameter int DIV_W      = 16,
  parameter int SEL_W      = 3,
  parameter int SYNC_N     = 2,
  parameter int RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic [DIV_W-1:0] baud_div,
  input  logic             width_mode,
  input  logic [SEL_W-1:0] width_sel,
  input  logic             tx_serial,
  output logic             ir_tx,
  input  logic             ir_rx,
  output logic             rx_serial
);
  logic     rst_sync_n;
  pw_mode_e mode_sel;

  assign mode_sel = pw_mode_e'(width_mode);

  irsir_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  irsir_tx_pulse #(.DIV_W(DIV_W), .SEL_W(SEL_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bit_tick  (bit_tick),
    .tx_serial (tx_serial),
    .baud_div  (baud_div),
    .mode      (mode_sel),
    .width_sel (width_sel),
    .ir_tx     (ir_tx)
  );

  irsir_rx_decode #(.DIV_W(DIV_W), .SYNC_N(SYNC_N)) u_rx (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .ir_rx     (ir_rx),
    .baud_div  (baud_div),
    .rx_serial (rx_serial)
  );
endmodule

// File: rtl/irsir_codec_chk.sv
module irsir_codec_chk #(
  parameter int SYNC_N = 2
) (
  input logic clk,
  input logic rst_sn,
  input logic bit_tick,
  input logic tx_serial,
  input logic ir_tx,
  input logic ir_rx,
  input logic rx_serial
);
  logic [3:0] up_q;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)             up_q <= '0;
    else if (up_q != 4'hF)   up_q <= up_q + 4'd1;
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_sn |-> (!ir_tx && rx_serial));

  p_one_quiet_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    (bit_tick && tx_serial) |=> !ir_tx);

  p_zero_pulse_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    (bit_tick && !tx_serial) |=> ir_tx);

  // R5: a pulse can only begin right after a tick
  p_rise_after_tick_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    (up_q >= 4'd1 && $rose(ir_tx)) |-> $past(bit_tick));

  p_rx_drop_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    (up_q >= 4'(SYNC_N + 1) && $past(ir_rx, SYNC_N) && !$past(ir_rx, SYNC_N + 1))
    |=> !rx_serial);

  p_rx_release_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    (up_q >= 4'(SYNC_N + 2) && $rose(rx_serial))
    |-> !($past(ir_rx, SYNC_N + 1) && !$past(ir_rx, SYNC_N + 2)));
endmodule

bind irsir_codec irsir_codec_chk #(.SYNC_N(SYNC_N)) u_chk (
  .clk       (clk),
  .rst_sn    (rst_sync_n),
  .bit_tick  (bit_tick),
  .tx_serial (tx_serial),
  .ir_tx     (ir_tx),
  .ir_rx     (ir_rx),
  .rx_serial (rx_serial)
);

// File: tb/irsir_codec_tb.sv
module irsir_codec_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_tick = 1'b0;
  logic [15:0] baud_div = 16'd40;
  logic        width_mode = 1'b1;
  logic [2:0]  width_sel = 3'd0;
  logic        tx_serial = 1'b1;
  logic        ir_tx, rx_serial;
  logic        loop_en = 1'b0;
  logic        rx_drv = 1'b0;
  logic        ir_rx_w;

  int checks = 0;
  int failures = 0;
  bit model_on = 1'b0;
  bit done = 1'b0;

  int rem = 0, win = 0;
  bit h1 = 0, h2 = 0, h3 = 0;

  assign ir_rx_w = loop_en ? ir_tx : rx_drv;

  always #4 clk = ~clk;

  irsir_codec u_dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .baud_div(baud_div),
    .width_mode(width_mode), .width_sel(width_sel), .tx_serial(tx_serial),
    .ir_tx(ir_tx), .ir_rx(ir_rx_w), .rx_serial(rx_serial)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int pulse_len();
    int w;
    if (width_mode) return 1 << (int'(width_sel) + 1);
    w = (int'(baud_div) * 3) / 16;
    return (w == 0) ? 1 : w;
  endfunction

  // behavioural reference, advanced at each rising edge
  always @(posedge clk) begin
    if (model_on) begin
      if (bit_tick) rem = tx_serial ? 0 : pulse_len();
      else if (rem > 0) rem = rem - 1;
      if (h2 && !h3) win = (baud_div == 0) ? 1 : int'(baud_div);
      else if (win > 0) win = win - 1;
      h3 = h2; h2 = h1; h1 = ir_rx_w;
    end
  end

  always @(negedge clk) begin
    if (model_on && !done) begin
      chk(ir_tx == (rem > 0), width_mode ? "R3 cycle" : "R4 cycle", ir_tx, rem > 0);
      chk(rx_serial == (win == 0), "R6 cycle", rx_serial, win == 0);
    end
  end

  // one bit period; returns ir_tx high count and rx_serial low count
  task automatic send_bit(input logic b, input bit chg, output int hi, output int lo);
    int div = int'(baud_div);
    hi = 0; lo = 0;
    tx_serial = b;
    bit_tick = 1'b1;
    @(negedge clk);
    bit_tick = 1'b0;
    for (int i = 0; i < div; i++) begin
      if (ir_tx) hi++;
      if (!rx_serial) lo++;
      if (chg && i == 2) begin
        width_mode = 1'b0;
        width_sel = 3'd0;
      end
      if (i < div - 1) @(negedge clk);
    end
  endtask

  task automatic idle(input int n, output int lo);
    lo = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!rx_serial) lo++;
    end
  endtask

  initial begin : watchdog
    #1500000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    int hi, lo, lo2, tot;
    repeat (5) @(negedge clk);
    chk(ir_tx == 1'b0, "R1 ir_tx in reset", ir_tx, 0);
    chk(rx_serial == 1'b1, "R1 rx_serial in reset", rx_serial, 1);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(ir_tx == 1'b0, "R1 ir_tx after reset", ir_tx, 0);
    chk(rx_serial == 1'b1, "R1 rx_serial after reset", rx_serial, 1);
    model_on = 1'b1;

    // R3: every fixed-width select
    baud_div = 16'd300;
    width_mode = 1'b1;
    for (int s = 0; s < 8; s++) begin
      width_sel = 3'(s);
      send_bit(1'b0, 1'b0, hi, lo);
      chk(hi == (2 << s), "R3 fixed width", hi, 2 << s);
      send_bit(1'b1, 1'b0, hi, lo);
      chk(hi == 0, "R2 one bit quiet", hi, 0);
    end

    // R9: settings changed inside a pulse are ignored
    width_sel = 3'd3;
    send_bit(1'b0, 1'b1, hi, lo);
    chk(hi == 16, "R9 mid-pulse change", hi, 16);
    width_mode = 1'b1;

    // R4: fraction mode, including the one-clock floor
    width_mode = 1'b0;
    baud_div = 16'd40;
    send_bit(1'b0, 1'b0, hi, lo);
    chk(hi == 7, "R4 fraction div40", hi, 7);
    baud_div = 16'd16;
    send_bit(1'b0, 1'b0, hi, lo);
    chk(hi == 3, "R4 fraction div16", hi, 3);
    baud_div = 16'd5;
    send_bit(1'b0, 1'b0, hi, lo);
    chk(hi == 1, "R4 fraction floor", hi, 1);
    send_bit(1'b1, 1'b0, hi, lo);
    chk(hi == 0, "R2 one bit fraction", hi, 0);

    // R5: ticks arrive while a 256-clock pulse is still high
    width_mode = 1'b1;
    width_sel = 3'd7;
    baud_div = 16'd100;
    send_bit(1'b0, 1'b0, hi, lo);
    chk(hi == 100, "R5 first long pulse", hi, 100);
    send_bit(1'b0, 1'b0, hi, lo);
    chk(hi == 100, "R5 restart on zero", hi, 100);
    send_bit(1'b1, 1'b0, hi, lo);
    chk(hi == 0, "R5 cut by one bit", hi, 0);
    idle(10, lo);

    // R6/R7: single-clock received pulse, latency and window length
    baud_div = 16'd50;
    rx_drv = 1'b1;
    @(negedge clk);
    rx_drv = 1'b0;
    chk(rx_serial == 1'b1, "R6 latency edge+0", rx_serial, 1);
    @(negedge clk);
    chk(rx_serial == 1'b1, "R6 latency edge+1", rx_serial, 1);
    @(negedge clk);
    chk(rx_serial == 1'b0, "R7 one-clock pulse decoded", rx_serial, 0);
    idle(120, lo);
    chk(lo + 1 == 50, "R6 window length", lo + 1, 50);

    // R7: wide received pulse still gives one window
    rx_drv = 1'b1;
    idle(10, lo);
    rx_drv = 1'b0;
    idle(120, lo2);
    chk(lo + lo2 == 50, "R7 wide pulse window", lo + lo2, 50);

    // R8: second pulse inside the window restarts it
    rx_drv = 1'b1;
    @(negedge clk);
    rx_drv = 1'b0;
    idle(29, lo);
    rx_drv = 1'b1;
    @(negedge clk);
    rx_drv = 1'b0;
    if (!rx_serial) lo++;
    idle(150, lo2);
    chk(lo + lo2 == 80, "R8 retrigger", lo + lo2, 80);

    // loopback: encoder feeding decoder
    loop_en = 1'b1;
    width_sel = 3'd0;
    baud_div = 16'd40;
    tot = 0;
    send_bit(1'b0, 1'b0, hi, lo); tot += lo;
    chk(hi == 2, "R3 loopback pulse", hi, 2);
    send_bit(1'b1, 1'b0, hi, lo); tot += lo;
    send_bit(1'b0, 1'b0, hi, lo); tot += lo;
    send_bit(1'b1, 1'b0, hi, lo); tot += lo;
    chk(tot == 80, "R6 loopback decode", tot, 80);
    idle(5, lo);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule